// File: doc/BRIEF.md
# Mode-Selectable Multiply-Add Output Stage

This block is a four-lane signed multiplier slice with a shared output stage. Each lane multiplies two 18-bit operands. A static mode input routes the lane products through one adder/subtractor/accumulator and one summation path. The stage can present a single product, keep a running sum, add or subtract two or four products, or combine all four partial products into one 36×36 product. An optional register after the multipliers and an optional output register set the latency.

Operands enter as packed lane vectors. `in_en` marks a cycle that carries a new operand set. A cycle with `in_en` low is a bubble: it moves through the pipeline without producing a result and does not touch the accumulator. `res_valid` pulses once for each accepted operand set, in the cycle its result appears on `result`. The mode must only change while the pipeline is empty.

Top module: `dsp_madd_stage`

## Requirements
- R1: In product mode (`mode` = 0, and the unused codes 5, 6 and 7), `result` is the signed product of lane 0, `a_in[17:0]` × `b_in[17:0]`, sign-extended to 72 bits. `sub` has no effect in this mode.
- R2: In two-product mode (`mode` = 2), `result` is p0 + p1 when `sub` = 0 and p0 − p1 when `sub` = 1. Here pi is the signed product of lane i, and lane i occupies bits [18i+17:18i] of `a_in` and of `b_in`.
- R3: In four-product mode (`mode` = 3), `result` is p0 + p1 + p2 + p3 when `sub` = 0 and p0 − p1 + p2 − p3 when `sub` = 1.
- R4: In wide mode (`mode` = 4), `result` is the signed 72-bit product of {a_in[35:18], a_in[17:0]} and {b_in[35:18], b_in[17:0]}. Lane 1 holds the signed upper halves and lane 0 holds the unsigned lower halves. Lanes 2 and 3 of the inputs and `sub` have no effect.
- R5: In accumulate mode (`mode` = 1), each accepted input adds p0 to an ACCW-bit running sum (or subtracts it when `sub` = 1). The sum wraps modulo 2^ACCW, and `result` is the sum sign-extended to 72 bits.
- R6: An accepted input with `acc_clr` = 1 loads ±p0 into the running sum and discards the previous value.
- R7: A cycle with `in_en` = 0 leaves the running sum unchanged and produces no `res_valid` pulse, whatever the operands are.
- R8: Outside accumulate mode, a result appears 1 + PIPE_EN + OUTREG_EN cycles after its operands are accepted. `res_valid` is high in exactly that cycle.
- R9: In accumulate mode the output register is always used, so the latency is 2 + PIPE_EN whatever the value of OUTREG_EN.
- R10: While `rst_n` is low, and until the first result arrives, `result` is 0 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | Operand set present this cycle |
| mode | input | 3 | Output-stage mode: 0 product, 1 accumulate, 2 two-product, 3 four-product, 4 wide |
| sub | input | 1 | Subtract the odd lanes (two-product and four-product modes) or subtract p0 (accumulate mode) |
| acc_clr | input | 1 | Load the sum instead of adding to it (accumulate mode) |
| a_in | input | 4*OPW | Multiplicand operands, lane i at [OPW*i +: OPW] |
| b_in | input | 4*OPW | Multiplier operands, lane i at [OPW*i +: OPW] |
| result | output | 4*OPW | Stage result, sign-extended |
| res_valid | output | 1 | Result on `result` is new this cycle |

## Verification
The operand patterns include the most negative 18-bit value in every lane. This separates correct sign handling from overflow in the two-product and four-product sums. Wide-mode vectors use lower halves with bit 17 set and upper halves at the extremes of their range; a design that treats the lower halves as signed, or shifts a cross product to the wrong position, gives a different result. Accumulation is run on a narrow accumulator until it wraps, and also with subtraction, a mid-stream clear, and bubbles that carry large operands. A second instance without pipeline or output register exposes any latency that depends on the mode.

// File: rtl/dsp_madd_pkg.sv
package dsp_madd_pkg;
   typedef enum logic [2:0] {
      MD_PROD = 3'd0,
      MD_ACC  = 3'd1,
      MD_SUM2 = 3'd2,
      MD_SUM4 = 3'd3,
      MD_WIDE = 3'd4
   } dsp_mode_e;

   localparam int NLANE = 4;
endpackage

// File: rtl/dsp_lane_mult.sv
module dsp_lane_mult #(
   parameter int OPW     = 18,
   parameter int PIPE_EN = 1,
   localparam int EW     = OPW + 1,
   localparam int PW     = 2 * EW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OPW-1:0]       a_op,
   input  logic [OPW-1:0]       b_op,
   input  logic                 a_uns,
   input  logic                 b_uns,
   output logic signed [PW-1:0] prod
);
   logic signed [EW-1:0] a_q, b_q;
   logic signed [PW-1:0] mult;

   // operand register; one extra bit carries sign or zero extension
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         a_q <= {(~a_uns) & a_op[OPW-1], a_op};
         b_q <= {(~b_uns) & b_op[OPW-1], b_op};
      end
   end

   assign mult = a_q * b_q;

   generate
      if (PIPE_EN != 0) begin : g_pipe
         logic signed [PW-1:0] p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) p_q <= '0;
            else        p_q <= mult;
         end
         assign prod = p_q;
      end else begin : g_nopipe
         assign prod = mult;
      end
   endgenerate
endmodule

// File: rtl/dsp_ctl_delay.sv
module dsp_ctl_delay #(
   parameter int W = 3,
   parameter int D = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [D];

   generate
      for (genvar k = 0; k < D; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      st[k] <= '0;
            else if (k == 0) st[k] <= d;
            else             st[k] <= st[(k == 0) ? 0 : k - 1];
         end
      end
   endgenerate

   assign q = st[D-1];
endmodule

// File: rtl/dsp_combine.sv
module dsp_combine
   import dsp_madd_pkg::*;
#(
   parameter int OPW  = 18,
   parameter int ACCW = 52,
   localparam int PW  = 2 * (OPW + 1),
   localparam int RW  = 4 * OPW
) (
   input  logic [2:0]              mode,
   input  logic                    sub,
   input  logic                    clr,
   input  logic [NLANE*PW-1:0]     prods,
   input  logic signed [ACCW-1:0]  acc_q,
   output logic signed [RW-1:0]    sum_res,
   output logic signed [ACCW-1:0]  acc_nxt
);
   logic signed [RW-1:0]   e [NLANE];
   logic signed [RW-1:0]   t1, t3;
   logic signed [ACCW-1:0] base, p_acc;

   always_comb begin
      for (int i = 0; i < NLANE; i++) e[i] = $signed(prods[i*PW +: PW]);
      t1 = sub ? -e[1] : e[1];
      t3 = sub ? -e[3] : e[3];
      case (mode)
         MD_SUM2: sum_res = e[0] + t1;
         MD_SUM4: sum_res = (e[0] + t1) + (e[2] + t3);
         MD_WIDE: sum_res = (e[1] <<< (2 * OPW)) + ((e[2] + e[3]) <<< OPW) + e[0];
         default: sum_res = e[0];
      endcase
      p_acc   = e[0][ACCW-1:0];
      base    = clr ? '0 : acc_q;
      acc_nxt = sub ? base - p_acc : base + p_acc;
   end
endmodule

// File: rtl/dsp_madd_stage.sv
module dsp_madd_stage
   import dsp_madd_pkg::*;
#(
   parameter int OPW       = 18,
   parameter int ACCW      = 52,
   parameter int PIPE_EN   = 1,
   parameter int OUTREG_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_en,
   input  logic [2:0]        mode,
   input  logic              sub,
   input  logic              acc_clr,
   input  logic [4*OPW-1:0]  a_in,
   input  logic [4*OPW-1:0]  b_in,
   output logic [4*OPW-1:0]  result,
   output logic              res_valid
);
   localparam int PW   = 2 * (OPW + 1);
   localparam int RW   = 4 * OPW;
   localparam int MLAT = 1 + PIPE_EN;

   generate
      if (OPW < 2)                             $error("OPW must be at least 2");
      if (ACCW < 2 * OPW + 1 || ACCW > RW)     $error("ACCW out of range");
      if (PIPE_EN < 0 || PIPE_EN > 1)          $error("PIPE_EN must be 0 or 1");
      if (OUTREG_EN < 0 || OUTREG_EN > 1)      $error("OUTREG_EN must be 0 or 1");
   endgenerate

   logic                  wide;
   logic [OPW-1:0]        la [NLANE];
   logic [OPW-1:0]        lb [NLANE];
   logic [NLANE-1:0]      ua, ub;
   logic [NLANE*PW-1:0]   prods;

   // lane routing: wide mode feeds the cross products to lanes 2 and 3
   always_comb begin
      wide = (mode == MD_WIDE);
      for (int i = 0; i < NLANE; i++) begin
         la[i] = a_in[i*OPW +: OPW];
         lb[i] = b_in[i*OPW +: OPW];
         ua[i] = 1'b0;
         ub[i] = 1'b0;
      end
      if (wide) begin
         ua[0] = 1'b1;  ub[0] = 1'b1;
         la[2] = a_in[OPW +: OPW];  lb[2] = b_in[0 +: OPW];  ub[2] = 1'b1;
         la[3] = a_in[0 +: OPW];    lb[3] = b_in[OPW +: OPW]; ua[3] = 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NLANE; g++) begin : g_lane
         logic signed [PW-1:0] p;
         dsp_lane_mult #(.OPW(OPW), .PIPE_EN(PIPE_EN)) u_mult (
            .clk(clk), .rst_n(rst_n),
            .a_op(la[g]), .b_op(lb[g]), .a_uns(ua[g]), .b_uns(ub[g]),
            .prod(p)
         );
         assign prods[g*PW +: PW] = p;
      end
   endgenerate

   logic m_vld, m_sub, m_clr;
   dsp_ctl_delay #(.W(3), .D(MLAT)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .d({in_en, sub, acc_clr}),
      .q({m_vld, m_sub, m_clr})
   );

   logic signed [ACCW-1:0] acc_q, acc_nxt;
   logic signed [RW-1:0]   sum_res, acc_ext, out_data;
   logic                   vld_q, out_vld;

   dsp_combine #(.OPW(OPW), .ACCW(ACCW)) u_comb (
      .mode(mode), .sub(m_sub), .clr(m_clr), .prods(prods),
      .acc_q(acc_q), .sum_res(sum_res), .acc_nxt(acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= m_vld;
         if (m_vld && mode == MD_ACC) acc_q <= acc_nxt;
      end
   end

   assign acc_ext = acc_q;

   generate
      if (OUTREG_EN != 0) begin : g_oreg
         logic signed [RW-1:0] res_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= sum_res;
         end
         assign out_data = res_q;
         assign out_vld  = vld_q;
      end else begin : g_noreg
         assign out_data = sum_res;
         assign out_vld  = m_vld;
      end
   endgenerate

   always_comb begin
      if (mode == MD_ACC) begin
         result    = acc_ext;
         res_valid = vld_q;
      end else begin
         result    = out_data;
         res_valid = out_vld;
      end
   end
endmodule

// File: rtl/dsp_madd_checker.sv
module dsp_madd_checker
   import dsp_madd_pkg::*;
#(
   parameter int OPW       = 18,
   parameter int PIPE_EN   = 1,
   parameter int OUTREG_EN = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_en,
   input logic [2:0]       mode,
   input logic [4*OPW-1:0] result,
   input logic             res_valid
);
   localparam int RW = 4 * OPW;
   localparam int LN = 1 + PIPE_EN + OUTREG_EN;
   localparam int LA = 2 + PIPE_EN;

   p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!res_valid && result == '0));

   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MD_ACC && $stable(mode)) |-> (res_valid == $past(in_en, LN)));

   p_acc_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_ACC && $stable(mode)) |-> (res_valid == $past(in_en, LA)));

   p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_ACC && $stable(mode) && !res_valid) |-> $stable(result));

   p_prod_ext_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PROD && res_valid) |->
         ((&result[RW-1:2*OPW-1]) || !(|result[RW-1:2*OPW-1])));

   p_sum2_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_SUM2 && res_valid) |->
         ((&result[RW-1:2*OPW]) || !(|result[RW-1:2*OPW])));
endmodule

bind dsp_madd_stage dsp_madd_checker #(
   .OPW(OPW), .PIPE_EN(PIPE_EN), .OUTREG_EN(OUTREG_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_en(in_en), .mode(mode),
   .result(result), .res_valid(res_valid)
);

// File: tb/dsp_madd_stage_bench.sv
module dsp_madd_stage_bench;
   typedef struct packed {
      logic [2:0]  md;
      logic        sb;
      logic [17:0] a0, a1, a2, a3, b0, b1, b2, b3;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 1'b0, 18'd3,      18'd7,      18'd7,     18'd7,     18'h3FFFB, 18'd7,     18'd7,     18'd7},
      '{3'd0, 1'b0, 18'h20000,  18'd1,      18'd1,     18'd1,     18'h20000, 18'd1,     18'd1,     18'd1},
      '{3'd6, 1'b0, 18'h1FFFF,  18'd9,      18'd9,     18'd9,     18'h20000, 18'd9,     18'd9,     18'd9},
      '{3'd0, 1'b1, 18'd4,      18'd5,      18'd5,     18'd5,     18'd4,     18'd5,     18'd5,     18'd5},
      '{3'd2, 1'b0, 18'd100,    18'h3FFFD,  18'd0,     18'd0,     18'd200,   18'd50,    18'd0,     18'd0},
      '{3'd2, 1'b1, 18'd100,    18'h3FFFD,  18'd0,     18'd0,     18'd200,   18'd50,    18'd0,     18'd0},
      '{3'd3, 1'b0, 18'h20000,  18'h20000,  18'h20000, 18'h20000, 18'h20000, 18'h20000, 18'h20000, 18'h20000},
      '{3'd3, 1'b1, 18'd1,      18'd2,      18'd3,     18'd4,     18'd10,    18'd10,    18'd10,    18'd10},
      '{3'd4, 1'b0, 18'd5,      18'd0,      18'h155,   18'h155,   18'd7,     18'd0,     18'h155,   18'h155},
      '{3'd4, 1'b0, 18'h3FFFF,  18'd0,      18'h155,   18'h155,   18'd2,     18'd0,     18'h155,   18'h155},
      '{3'd4, 1'b0, 18'd0,      18'h20000,  18'h155,   18'h155,   18'd0,     18'h20000, 18'h155,   18'h155},
      '{3'd4, 1'b0, 18'h3FFFF,  18'h1FFFF,  18'h155,   18'h155,   18'h3FFFF, 18'h3FFFF, 18'h155,   18'h155},
      '{3'd4, 1'b1, 18'h2ABCD,  18'h3F123,  18'h155,   18'h155,   18'h3C001, 18'h00456, 18'h155,   18'h155}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_en = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic        sub = 1'b0;
   logic        acc_clr = 1'b0;
   logic [71:0] a_in = '0, b_in = '0;
   logic [71:0] res1, res2;
   logic        vld1, vld2;

   int  n_chk = 0;
   int  n_err = 0;
   bit  done = 1'b0;
   logic signed [51:0] acc1 = '0;
   logic signed [39:0] acc2 = '0;

   always #2 clk = ~clk;

   dsp_madd_stage u_dsp_madd_stage (
      .clk(clk), .rst_n(rst_n), .in_en(in_en), .mode(mode), .sub(sub),
      .acc_clr(acc_clr), .a_in(a_in), .b_in(b_in), .result(res1), .res_valid(vld1)
   );

   dsp_madd_stage #(.ACCW(40), .PIPE_EN(0), .OUTREG_EN(0)) u_dsp_madd_stage_lite (
      .clk(clk), .rst_n(rst_n), .in_en(in_en), .mode(mode), .sub(sub),
      .acc_clr(acc_clr), .a_in(a_in), .b_in(b_in), .result(res2), .res_valid(vld2)
   );

   task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic signed [71:0] ref_of(input vec_t v);
      logic signed [35:0] p0, p1, p2, p3;
      logic signed [71:0] r;
      p0 = $signed(v.a0) * $signed(v.b0);
      p1 = $signed(v.a1) * $signed(v.b1);
      p2 = $signed(v.a2) * $signed(v.b2);
      p3 = $signed(v.a3) * $signed(v.b3);
      case (v.md)
         3'd2:    r = v.sb ? p0 - p1 : p0 + p1;
         3'd3:    r = v.sb ? (p0 - p1) + (p2 - p3) : (p0 + p1) + (p2 + p3);
         3'd4:    r = $signed({v.a1, v.a0}) * $signed({v.b1, v.b0});
         default: r = p0;
      endcase
      return r;
   endfunction

   function automatic string req_of(input logic [2:0] md);
      case (md)
         3'd2:    return "R2";
         3'd3:    return "R3";
         3'd4:    return "R4";
         default: return "R1";
      endcase
   endfunction

   task automatic acc_step(input logic clr, input logic sb, input logic [17:0] a0, input logic [17:0] b0);
      logic signed [35:0] p;
      @(negedge clk);
      in_en = 1'b1; acc_clr = clr; sub = sb;
      a_in = {54'd0, a0}; b_in = {54'd0, b0};
      p = $signed(a0) * $signed(b0);
      acc1 = sb ? (clr ? 52'sd0 : acc1) - p : (clr ? 52'sd0 : acc1) + p;
      acc2 = sb ? (clr ? 40'sd0 : acc2) - p[35:0] : (clr ? 40'sd0 : acc2) + p[35:0];
   endtask

   task automatic drain_and_check_acc(input string req);
      logic signed [71:0] e1, e2;
      @(negedge clk);
      in_en = 1'b0; acc_clr = 1'b0;
      repeat (4) @(negedge clk);
      e1 = acc1; e2 = acc2;
      chk({req, " acc52"}, res1, e1);
      chk({req, " acc40"}, res2, e2);
   endtask

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 result1 in reset", res1, '0);
      chk("R10 valid1 in reset", {71'd0, vld1}, 72'd0);
      chk("R10 valid2 in reset", {71'd0, vld2}, 72'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 result1 after reset", res1, '0);
      chk("R10 result2 after reset", res2, '0);

      // table walk: one operand set at a time, latency 1 (lite) and 3 (default)
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic signed [71:0] exp;
         v = VECS[i];
         exp = ref_of(v);
         @(negedge clk);
         mode = v.md; sub = v.sb; in_en = 1'b1;
         a_in = {v.a3, v.a2, v.a1, v.a0};
         b_in = {v.b3, v.b2, v.b1, v.b0};
         @(negedge clk);
         in_en = 1'b0;
         a_in = '1; b_in = '1;
         chk({req_of(v.md), " lite value"}, res2, exp);
         chk("R8 lite valid at latency 1", {71'd0, vld2}, 72'd1);
         chk("R8 default valid early", {71'd0, vld1}, 72'd0);
         @(negedge clk);
         @(negedge clk);
         chk({req_of(v.md), " default value"}, res1, exp);
         chk("R8 default valid at latency 3", {71'd0, vld1}, 72'd1);
         @(negedge clk);
         chk("R8 single valid pulse", {71'd0, vld1}, 72'd0);
      end

      // accumulate: wrap on the 40-bit accumulator, no wrap on 52 bits (R5, R6)
      @(negedge clk);
      mode = 3'd1;
      acc_step(1'b1, 1'b0, 18'h20000, 18'h20000);
      for (int k = 0; k < 39; k++) acc_step(1'b0, 1'b0, 18'h20000, 18'h20000);
      drain_and_check_acc("R5 wrap");
      chk("R5 acc40 wrapped negative", res2, {{32{1'b1}}, 40'h_A000000000});

      // R9: accumulate latency with output register disabled; R6 clear
      @(negedge clk);
      in_en = 1'b1; acc_clr = 1'b1; sub = 1'b0;
      a_in = {54'd0, 18'd7}; b_in = {54'd0, 18'd3};
      acc1 = 52'sd21; acc2 = 40'sd21;
      @(negedge clk);
      in_en = 1'b0; acc_clr = 1'b0;
      chk("R9 lite no valid at 1 cycle", {71'd0, vld2}, 72'd0);
      @(negedge clk);
      chk("R9 lite valid at 2 cycles", {71'd0, vld2}, 72'd1);
      chk("R6 clear loads product", res2, 72'd21);
      @(negedge clk);
      chk("R9 default valid at 3 cycles", {71'd0, vld1}, 72'd1);
      chk("R6 clear loads product default", res1, 72'd21);

      // R7 bubbles with large operands, R5 subtract
      acc_step(1'b0, 1'b1, 18'd2, 18'd5);
      @(negedge clk);
      in_en = 1'b0; a_in = {54'd0, 18'd1000}; b_in = {54'd0, 18'd1000};
      repeat (3) @(negedge clk);
      acc_step(1'b0, 1'b0, 18'd1, 18'd1);
      drain_and_check_acc("R7 bubble");
      chk("R7 sum after bubble", res1, 72'd12);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule